// File: doc/BRIEF.md
# SPI Serial NOR Read Responder

This block is the target side of a serial NOR memory model, limited to the commands that read data. It watches the chip-select, serial-clock and serial-in pins. It samples them with a much faster system clock, and it decodes a one-byte command and, where the command has one, a three-byte address. It then streams bytes back on one or two output pins. The stored data sits in an internal byte array of 2^AW entries. That array is loaded through a valid/ready write port while the bus is idle.

Six commands are understood:

- Two single-pin array reads. One has no wait byte and one has a single wait byte.
- An array read that sends each byte as bit pairs on two pins.
- Three identification streams.

Any other command byte makes the block silent until chip select is released. Raising chip select always returns the block to waiting for a command.

The preload port follows these back-pressure rules. `pl_ready` is high only while the synchronised chip select shows the bus deselected. A byte is written on every clock where `pl_valid` and `pl_ready` are both high. A source that holds `pl_valid` while `pl_ready` is low simply waits, and no write takes place.

Timing has two limits. The serial clock's high and low times must each last at least four system clock periods. Each new output bit appears within three system clocks after the falling serial-clock edge that launches it.

Top module: `snor_read_front`

## Requirements
- R1: Both serial-clock idle levels are accepted: low idle (mode 0) and high idle (mode 3). Input bits are captured on rising edges. Output bits change only after falling edges. All command, address and data bytes travel most significant bit first.
- R2: Command 03h, followed by a 24-bit address, returns array data on io1 starting with the first clock after the address.
- R3: Command 0Bh, followed by an address and one wait byte of any value, returns array data starting after the wait byte.
- R4: Command 3Bh is timed like 0Bh but sends each byte in four clocks. io1 carries bits 7,5,3,1 and io0 carries bits 6,4,2,0, in that order. io0_oe is high only during this data phase.
- R5: Array reads continue while clocks arrive, with the address incrementing after every byte. After address 2^AW-1 the next byte comes from address 0.
- R6: Command 9Fh returns 8Ch, 30h, 11h, and then starts again at 8Ch.
- R7: Command ABh, followed by three wait bytes, returns 10h on every following byte.
- R8: Command 90h is followed by three address bytes. When bit 0 of the last address byte is 0, output alternates 8Ch then 10h. When that bit is 1, output alternates 10h then 8Ch.
- R9: Raising chip select at any point, even in the middle of a byte, ends the command, and the next selection starts a fresh command. Both output enables are low while deselected and during every command, address and wait phase.
- R10: An unrecognised command byte leaves both output enables low for the rest of that selection. Commands after the next deselection work normally.
- R11: `pl_ready` is low while chip select is low, and a `pl_valid` presented then writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cs_n | input | 1 | Chip select from the bus, active low |
| pin_sck | input | 1 | Serial clock from the bus |
| pin_si | input | 1 | Serial data from the bus master |
| pl_valid | input | 1 | Preload byte offered |
| pl_ready | output | 1 | Preload byte accepted; high only while the bus is deselected |
| pl_addr | input | AW | Preload array address |
| pl_data | input | 8 | Preload byte value |
| io0_out | output | 1 | Data on the serial-in pin during two-pin reads |
| io0_oe | output | 1 | Drive enable for io0 |
| io1_out | output | 1 | Serial output data |
| io1_oe | output | 1 | Drive enable for io1 |

## Verification
The hardest case to reach from the pins is a chip-select release that lands partway through a byte. After such a release, the internal bit counter must not leak stale bits into the next command. The stimulus stops an address three bits into a byte, deselects, and then issues a complete command with a wait byte. That command only returns correct data if framing restarted at bit zero. Mode 3 adds a falling clock edge before the first rising edge. The same read is therefore repeated with the clock idling high, to show that this extra edge neither shifts capture nor starts output early.

// File: rtl/snor_pkg.sv
package snor_pkg;
  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_FAST      = 8'h0B;
  localparam logic [7:0] OP_FAST_DUAL = 8'h3B;
  localparam logic [7:0] OP_JEDEC_ID  = 8'h9F;
  localparam logic [7:0] OP_SIG       = 8'hAB;
  localparam logic [7:0] OP_MFR_ID    = 8'h90;

  localparam logic [7:0] ID_MAKER = 8'h8C;
  localparam logic [7:0] ID_TYPE  = 8'h30;
  localparam logic [7:0] ID_CAP   = 8'h11;
  localparam logic [7:0] ID_SIG   = 8'h10;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_DUMMY, PH_STREAM, PH_MUTE
  } phase_e;

  typedef enum logic [1:0] {
    SRC_ARRAY, SRC_JEDEC, SRC_SIG, SRC_MFR
  } src_e;
endpackage

// File: rtl/snor_pin_sync.sv
module snor_pin_sync #(
  parameter int            N       = 3,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[g]}};
      else        st <= {st[0], pin_i[g]};
    end
    assign sync_o[g] = st[1];
  end
endmodule

// File: rtl/snor_byte_mem.sv
module snor_byte_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/snor_cmd_engine.sv
module snor_cmd_engine
  import snor_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desel,
  input  logic          sck_lvl,
  input  logic          si_lvl,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          io0_out,
  output logic          io0_oe,
  output logic          io1_out,
  output logic          io1_oe
);
  logic          sck_d;
  logic          rise, fall;
  logic [2:0]    bit_q;
  logic [6:0]    in_sh;
  logic [7:0]    in_byte;
  logic          byte_done;
  phase_e        ph_q;
  src_e          src_q;
  logic          dual_q, need_dummy_q, swap_q, tog_q, drive_q;
  logic [1:0]    left_q, idx_q;
  logic [AW-2:0] addr_q;
  logic [AW-1:0] addr_next, ptr_q;
  logic [7:0]    osh_q, src_byte;
  logic [2:0]    obit_q;
  logic          last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_lvl;
  end

  assign rise      = sck_lvl & ~sck_d & ~desel;
  assign fall      = ~sck_lvl & sck_d & ~desel;
  assign in_byte   = {in_sh, si_lvl};
  assign byte_done = rise && (bit_q == 3'd7);
  assign addr_next = {addr_q, si_lvl};
  assign last_bit  = dual_q ? (obit_q == 3'd3) : (obit_q == 3'd7);

  always_comb begin
    case (src_q)
      SRC_ARRAY: src_byte = mem_rdata;
      SRC_JEDEC: src_byte = (idx_q == 2'd0) ? ID_MAKER :
                            (idx_q == 2'd1) ? ID_TYPE : ID_CAP;
      SRC_SIG:   src_byte = ID_SIG;
      default:   src_byte = (tog_q ^ swap_q) ? ID_SIG : ID_MAKER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; in_sh <= '0; ph_q <= PH_OPCODE; src_q <= SRC_ARRAY;
      dual_q <= 1'b0; need_dummy_q <= 1'b0; swap_q <= 1'b0; tog_q <= 1'b0;
      drive_q <= 1'b0; left_q <= '0; idx_q <= '0; addr_q <= '0; ptr_q <= '0;
      osh_q <= '0; obit_q <= '0; io0_out <= 1'b0; io1_out <= 1'b0;
    end else if (desel) begin
      bit_q <= '0; ph_q <= PH_OPCODE; src_q <= SRC_ARRAY;
      dual_q <= 1'b0; need_dummy_q <= 1'b0; tog_q <= 1'b0;
      drive_q <= 1'b0; left_q <= '0; idx_q <= '0;
      obit_q <= '0; io0_out <= 1'b0; io1_out <= 1'b0;
    end else begin
      if (rise) begin
        bit_q <= bit_q + 3'd1;
        in_sh <= in_byte[6:0];
        if (ph_q == PH_ADDR) addr_q <= addr_next[AW-2:0];
      end
      if (byte_done) begin
        case (ph_q)
          PH_OPCODE: begin
            case (in_byte)
              OP_READ:      begin ph_q <= PH_ADDR; left_q <= 2'd2; src_q <= SRC_ARRAY; need_dummy_q <= 1'b0; end
              OP_FAST:      begin ph_q <= PH_ADDR; left_q <= 2'd2; src_q <= SRC_ARRAY; need_dummy_q <= 1'b1; end
              OP_FAST_DUAL: begin ph_q <= PH_ADDR; left_q <= 2'd2; src_q <= SRC_ARRAY; need_dummy_q <= 1'b1; dual_q <= 1'b1; end
              OP_JEDEC_ID:  begin ph_q <= PH_STREAM; src_q <= SRC_JEDEC; end
              OP_SIG:       begin ph_q <= PH_DUMMY; left_q <= 2'd2; src_q <= SRC_SIG; end
              OP_MFR_ID:    begin ph_q <= PH_ADDR; left_q <= 2'd2; src_q <= SRC_MFR; need_dummy_q <= 1'b0; end
              default:      ph_q <= PH_MUTE;
            endcase
          end
          PH_ADDR: begin
            if (left_q == 2'd0) begin
              ptr_q  <= addr_next;
              swap_q <= si_lvl;
              ph_q   <= need_dummy_q ? PH_DUMMY : PH_STREAM;
            end else begin
              left_q <= left_q - 2'd1;
            end
          end
          PH_DUMMY: begin
            if (left_q == 2'd0) ph_q <= PH_STREAM;
            else                left_q <= left_q - 2'd1;
          end
          default: ;
        endcase
      end
      if (fall && ph_q == PH_STREAM) begin
        drive_q <= 1'b1;
        if (obit_q == 3'd0) begin
          io1_out <= src_byte[7];
          io0_out <= dual_q ? src_byte[6] : 1'b0;
          osh_q   <= dual_q ? {src_byte[5:0], 2'b00} : {src_byte[6:0], 1'b0};
        end else begin
          io1_out <= osh_q[7];
          io0_out <= dual_q ? osh_q[6] : 1'b0;
          osh_q   <= dual_q ? {osh_q[5:0], 2'b00} : {osh_q[6:0], 1'b0};
        end
        if (last_bit) begin
          obit_q <= '0;
          ptr_q  <= ptr_q + 1'b1;
          tog_q  <= ~tog_q;
          idx_q  <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
        end else begin
          obit_q <= obit_q + 3'd1;
        end
      end
    end
  end

  assign mem_raddr = ptr_q;
  assign io1_oe    = drive_q;
  assign io0_oe    = drive_q & dual_q;
endmodule

// File: rtl/snor_read_front.sv
module snor_read_front #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_cs_n,
  input  logic          pin_sck,
  input  logic          pin_si,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  output logic          io0_out,
  output logic          io0_oe,
  output logic          io1_out,
  output logic          io1_oe
);
  logic [2:0]    pins_s;
  logic          cs_n_s, sck_s, si_s;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  snor_pin_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({pin_si, pin_sck, pin_cs_n}),
    .sync_o(pins_s)
  );

  assign cs_n_s   = pins_s[0];
  assign sck_s    = pins_s[1];
  assign si_s     = pins_s[2];
  assign pl_ready = cs_n_s;

  snor_byte_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(pl_valid & pl_ready), .waddr(pl_addr), .wdata(pl_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  snor_cmd_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .desel(cs_n_s), .sck_lvl(sck_s), .si_lvl(si_s),
    .mem_rdata(rd_data), .mem_raddr(rd_addr),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe)
  );
endmodule

// File: rtl/snor_resp_chk.sv
module snor_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_s,
  input logic sck_s,
  input logic io0_oe,
  input logic io1_oe,
  input logic io1_out
);
  p_hiz_when_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!io1_oe && !io0_oe));

  p_io0_only_with_io1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> io1_oe);

  p_data_moves_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io1_oe && $past(io1_oe) && !$stable(io1_out)) |-> (!$past(sck_s) && $past(sck_s, 2)));

  p_drive_starts_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io1_oe) |-> (!$past(sck_s) && $past(sck_s, 2)));
endmodule

bind snor_read_front snor_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
  .io0_oe(io0_oe), .io1_oe(io1_oe), .io1_out(io1_out)
);

// File: tb/snor_read_front_bench.sv
`timescale 1ns/1ps
module snor_read_front_bench;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic pl_valid = 1'b0;
  logic pl_ready;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic io0_out, io0_oe, io1_out, io1_oe;

  int vectors = 0;
  int errors = 0;
  bit mode3 = 1'b0;
  bit seen1 = 1'b0, seen0 = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  snor_read_front #(.AW(AW)) u_snor_read_front (
    .clk(clk), .rst_n(rst_n), .pin_cs_n(cs_n), .pin_sck(sck), .pin_si(si),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr), .pl_data(pl_data),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe)
  );

  function automatic logic [7:0] pat(input int a);
    logic [31:0] v;
    v = a * 37 + (a >> 8) * 91 + 11;
    return v[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic o1, output logic o0);
    sck = 1'b0; si = b;
    #HALF;
    o1 = io1_out; o0 = io0_out;
    if (io1_oe) seen1 = 1'b1;
    if (io0_oe) seen0 = 1'b1;
    sck = 1'b1;
    #HALF;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic d1, d0;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], d1, d0);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic recv_byte(output logic [7:0] r);
    logic o1, o0;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b0, o1, o0);
      r = {r[6:0], o1};
    end
  endtask

  task automatic recv_dual(output logic [7:0] r);
    logic o1, o0;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      bit_cycle(1'b0, o1, o0);
      r = {r[5:0], o1, o0};
    end
  endtask

  task automatic begin_tx();
    sck = mode3;
    #HALF;
    cs_n = 1'b0;
    #HALF;
    seen1 = 1'b0; seen0 = 1'b0;
  endtask

  task automatic end_tx();
    if (!mode3) sck = 1'b0;
    #HALF;
    cs_n = 1'b1;
    #(HALF * 4);
  endtask

  task automatic t_reset();
    chk("R9 io1_oe after reset", io1_oe, 0);
    chk("R9 io0_oe after reset", io0_oe, 0);
    chk("R11 pl_ready while idle", pl_ready, 1);
  endtask

  task automatic t_read(input bit m3, input int base);
    logic [7:0] r;
    mode3 = m3;
    begin_tx(); send_byte(8'h03); send_addr(24'(base));
    chk("R9 no drive during command/address", seen1, 0);
    for (int i = 0; i < 4; i++) begin
      recv_byte(r);
      chk(m3 ? "R1 mode3 read byte" : "R2 read byte", r, pat((base + i) % DEPTH));
    end
    chk("R4 io0 idle in single read", seen0, 0);
    end_tx();
    mode3 = 1'b0;
  endtask

  task automatic t_fast();
    logic [7:0] r;
    begin_tx(); send_byte(8'h0B); send_addr(24'h0002F0); send_byte(8'hA5);
    chk("R3 no drive during wait byte", seen1, 0);
    for (int i = 0; i < 3; i++) begin
      recv_byte(r);
      chk("R3 fast read byte", r, pat(16'h2F0 + i));
    end
    end_tx();
  endtask

  task automatic t_dual();
    logic [7:0] r;
    begin_tx(); send_byte(8'h3B); send_addr(24'h000077); send_byte(8'h00);
    chk("R4 io0 idle before data", seen0, 0);
    for (int i = 0; i < 3; i++) begin
      recv_dual(r);
      chk("R4 dual byte", r, pat(8'h77 + i));
    end
    chk("R4 io0 driven in data phase", seen0, 1);
    end_tx();
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    begin_tx(); send_byte(8'h03); send_addr(24'(DEPTH - 2));
    for (int i = 0; i < 4; i++) begin
      recv_byte(r);
      chk("R5 wrap byte", r, pat((DEPTH - 2 + i) % DEPTH));
    end
    end_tx();
  endtask

  task automatic t_jedec();
    logic [7:0] r;
    logic [7:0] exp [4] = '{8'h8C, 8'h30, 8'h11, 8'h8C};
    begin_tx(); send_byte(8'h9F);
    for (int i = 0; i < 4; i++) begin
      recv_byte(r);
      chk("R6 identity byte", r, exp[i]);
    end
    end_tx();
  endtask

  task automatic t_sig();
    logic [7:0] r;
    begin_tx(); send_byte(8'hAB); send_addr(24'hFFFFFF);
    chk("R7 no drive during wait bytes", seen1, 0);
    for (int i = 0; i < 3; i++) begin
      recv_byte(r);
      chk("R7 signature byte", r, 8'h10);
    end
    end_tx();
  endtask

  task automatic t_mfr(input logic [7:0] last);
    logic [7:0] r;
    begin_tx(); send_byte(8'h90); send_addr({16'h0000, last});
    for (int i = 0; i < 4; i++) begin
      recv_byte(r);
      chk("R8 maker/device byte", r, ((i % 2) ^ last[0]) ? 8'h10 : 8'h8C);
    end
    end_tx();
  endtask

  task automatic t_abort();
    logic [7:0] r;
    logic d1, d0;
    begin_tx(); send_byte(8'h03); send_byte(8'h00);
    bit_cycle(1'b1, d1, d0); bit_cycle(1'b0, d1, d0); bit_cycle(1'b1, d1, d0);
    end_tx();
    chk("R9 idle after mid-byte abort", io1_oe, 0);
    begin_tx(); send_byte(8'h0B); send_addr(24'h000010); send_byte(8'h00);
    recv_byte(r);
    chk("R9 fresh command after abort", r, pat(16'h10));
    end_tx();
    begin_tx(); send_byte(8'h03); send_addr(24'h000020);
    recv_byte(r);
    chk("R9 drive while streaming", io1_oe, 1);
    end_tx();
    chk("R9 released after stream abort", io1_oe, 0);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    begin_tx(); send_byte(8'h5A); send_addr(24'h030000);
    recv_byte(r); recv_byte(r);
    chk("R10 silent after unknown command", seen1 | seen0, 0);
    end_tx();
    begin_tx(); send_byte(8'h9F); recv_byte(r);
    chk("R10 next selection works", r, 8'h8C);
    end_tx();
  endtask

  task automatic t_preload_blocked();
    logic [7:0] r;
    begin_tx();
    #(HALF * 4);
    chk("R11 pl_ready low while selected", pl_ready, 0);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = AW'(16'h40); pl_data = ~pat(16'h40);
    repeat (3) @(negedge clk);
    pl_valid = 1'b0;
    end_tx();
    begin_tx(); send_byte(8'h03); send_addr(24'h000040); recv_byte(r);
    chk("R11 refused write left array unchanged", r, pat(16'h40));
    end_tx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      pl_valid = 1'b1; pl_addr = AW'(a); pl_data = pat(a);
    end
    @(negedge clk);
    pl_valid = 1'b0;
    #(HALF * 2);
    t_read(1'b0, 16'h123);
    t_read(1'b1, 16'h0A1);
    t_fast();
    t_dual();
    t_wrap();
    t_jedec();
    t_sig();
    t_mfr(8'h00);
    t_mfr(8'h01);
    t_abort();
    t_unknown();
    t_preload_blocked();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule